// File: doc/BRIEF.md
# Parallel Host Port Peripheral Handshake Engine

This block is the device end of a byte-wide parallel host port. It runs the strobe/acknowledge handshakes for three transfer styles: compatibility mode, where the host sends print bytes; nibble mode, where the device returns bytes to the host four bits at a time on status lines; and ECP mode, where full bytes move in both directions. In ECP mode each forward byte carries a flag that marks it as data or command. The block also controls bus turnaround, which decides when the device drives the shared data lines.

Host control inputs pass through a two-flop synchronizer. Forward bytes go to the internal controller on a valid/ready receive stream together with their command flag. Bytes for the host come from a valid/ready transmit stream. A static register input selects the mode. Negotiation, deep buffering and run-length decoding are handled elsewhere.

Top module: `pp_periph`

## Requirements
- R1: After reset `busy_o`=0, `ack_no`=1, `pd_oe_o`=0, `rev_ack_no`=1 and `rx_valid_o`=0.
- R2: With `mode_i`=0 (compatibility), a low level on `strobe_ni` is seen through a two-flop synchronizer. On the third rising clock edge after `strobe_ni` falls, the byte on `pd_i` is presented on `rx_data_o` with `rx_valid_o`=1, and `busy_o` rises on the same edge.
- R3: While `rx_valid_o`=1 and `rx_ready_i`=0, `rx_valid_o`, `rx_data_o`, `rx_cmd_o` and `busy_o`=1 hold unchanged, and `ack_no` stays high.
- R4: In compatibility mode, once the byte has been accepted and the synchronized strobe is high, `ack_no` goes low for exactly ACK_W clock cycles (default 4). `busy_o` falls on the same edge on which `ack_no` returns high.
- R5: With `mode_i`=2 (ECP) and no reverse transfer active, a forward byte is captured as in R2, with `rx_cmd_o`=1 when `autofd_ni` is low and 0 when it is high. No `ack_no` pulse is produced. `busy_o` falls once the byte has been accepted and the strobe is high.
- R6: With `mode_i`=1 (nibble), while `autofd_ni` is low a byte is taken from the transmit stream with a single `tx_ready_o` beat. Bits 3:0 go out on `stat_o[3:0]` first, followed by bits 7:4. Each nibble is valid one cycle before `ack_no` falls. `ack_no` returns high after the host raises `autofd_ni`, and the next nibble starts after the host lowers it again.
- R7: With `mode_i`=2, a low `init_ni` requests reverse mode. `pd_oe_o` rises on the third edge after `init_ni` falls and `rev_ack_no` falls one edge later. When `init_ni` goes high, `pd_oe_o` falls on the third edge and `rev_ack_no` rises one edge later.
- R8: In ECP reverse mode with `autofd_ni` low, a transmit byte is driven on `pd_o` one cycle before `ack_no` falls. `ack_no` returns high after `autofd_ni` rises, and the next byte waits for `autofd_ni` to be low.
- R9: With `mode_i`=3 (off), strobes are ignored: `busy_o` and `rx_valid_o` stay 0 and `ack_no` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | 0 compatibility, 1 nibble, 2 ECP, 3 off |
| pd_i | input | 8 | Host data lines, input side |
| pd_o | output | 8 | Data driven toward the host in ECP reverse |
| pd_oe_o | output | 1 | Output enable for the data lines |
| strobe_ni | input | 1 | Host data strobe, active low |
| autofd_ni | input | 1 | Host feed line: command flag forward, handshake in nibble/reverse |
| init_ni | input | 1 | Host reverse request, active low |
| busy_o | output | 1 | Device busy |
| ack_no | output | 1 | Device acknowledge / reverse strobe, active low |
| rev_ack_no | output | 1 | Reverse grant, active low (paper-error line) |
| stat_o | output | 4 | Nibble-mode status lines |
| rx_data_o | output | 8 | Received byte |
| rx_cmd_o | output | 1 | Received byte is an ECP command |
| rx_valid_o | output | 1 | Receive stream valid |
| rx_ready_i | input | 1 | Receive stream ready |
| tx_data_i | input | 8 | Byte to send to the host |
| tx_valid_i | input | 1 | Transmit stream valid |
| tx_ready_o | output | 1 | Transmit stream ready |

## Verification
Every host line passes through two synchronizer flops. A forward capture and the turnaround enable are therefore due on the third rising edge after the host changes a line, and the reverse grant one edge after that. The bench drives inputs on falling edges and checks the cycle just before and the cycle exactly at those edges. Results that wait on host replies, such as acknowledge edges and busy release, are polled one falling edge at a time with a timeout. The acknowledge pulse width is measured as an exact count of cycles.

// File: rtl/pp_pkg.sv
`timescale 1ns/1ps
package pp_pkg;
  typedef enum logic [1:0] {
    MODE_COMPAT = 2'd0,
    MODE_NIBBLE = 2'd1,
    MODE_ECP    = 2'd2,
    MODE_OFF    = 2'd3
  } pp_mode_e;
endpackage

// File: rtl/pp_sync.sv
`timescale 1ns/1ps
module pp_sync #(
  parameter int            W       = 3,
  parameter logic [W-1:0]  RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[g];
        s2_q <= RST_VAL[g];
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/pp_fwd.sv
`timescale 1ns/1ps
module pp_fwd #(
  parameter int DW    = 8,
  parameter int ACK_W = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          ecp_i,
  input  logic [DW-1:0] pd_i,
  input  logic          strobe_s_i,
  input  logic          autofd_s_i,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_cmd_o,
  output logic          rx_valid_o,
  input  logic          rx_ready_i,
  output logic          busy_o,
  output logic          ack_no
);
  localparam int CW = $clog2(ACK_W + 1);

  typedef enum logic [1:0] {F_IDLE, F_HOLD, F_ACK} fwd_st_e;
  fwd_st_e       st_q;
  logic          stb_q;
  logic [CW-1:0] cnt_q;
  logic          fall;

  assign fall = stb_q & ~strobe_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= F_IDLE;
      stb_q      <= 1'b1;
      cnt_q      <= '0;
      rx_data_o  <= '0;
      rx_cmd_o   <= 1'b0;
      rx_valid_o <= 1'b0;
      busy_o     <= 1'b0;
      ack_no     <= 1'b1;
    end else begin
      stb_q <= strobe_s_i;
      if (rx_valid_o && rx_ready_i) rx_valid_o <= 1'b0;
      unique case (st_q)
        F_IDLE: if (en_i && fall) begin
          rx_data_o  <= pd_i;
          rx_cmd_o   <= ecp_i & ~autofd_s_i;
          rx_valid_o <= 1'b1;
          busy_o     <= 1'b1;
          st_q       <= F_HOLD;
        end
        F_HOLD: if ((!rx_valid_o || rx_ready_i) && strobe_s_i) begin
          if (ecp_i) begin
            busy_o <= 1'b0;
            st_q   <= F_IDLE;
          end else begin
            ack_no <= 1'b0;
            cnt_q  <= '0;
            st_q   <= F_ACK;
          end
        end
        F_ACK: begin
          if (cnt_q == CW'(ACK_W - 1)) begin
            ack_no <= 1'b1;
            busy_o <= 1'b0;
            st_q   <= F_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= F_IDLE;
      endcase
    end
  end

  p_valid_in_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> busy_o);
  p_rx_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o && !rx_ready_i |=> rx_valid_o && $stable(rx_data_o) && $stable(rx_cmd_o));
  p_ack_in_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_no |-> busy_o);
  p_ecp_no_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_no) |-> !ecp_i);
endmodule

// File: rtl/pp_rev.sv
`timescale 1ns/1ps
module pp_rev #(
  parameter int DW = 8,
  parameter int NW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          nib_i,
  input  logic          ecp_i,
  input  logic          autofd_s_i,
  input  logic          init_s_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          tx_valid_i,
  output logic          tx_ready_o,
  output logic [DW-1:0] pd_o,
  output logic          pd_oe_o,
  output logic          rev_ack_no,
  output logic          ack_no,
  output logic [NW-1:0] stat_o
);
  typedef enum logic [1:0] {R_IDLE, R_SET, R_LOW, R_REL} rev_st_e;
  rev_st_e       st_q;
  logic [DW-1:0] byte_q;
  logic          half_q;
  logic          granted;

  assign granted    = ecp_i & pd_oe_o & ~rev_ack_no;
  assign tx_ready_o = (st_q == R_IDLE) & (nib_i | granted) & ~autofd_s_i;

  // turnaround: enable follows host release, grant trails enable both ways
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_oe_o    <= 1'b0;
      rev_ack_no <= 1'b1;
    end else if (!ecp_i) begin
      pd_oe_o    <= 1'b0;
      rev_ack_no <= 1'b1;
    end else if (!init_s_i) begin
      pd_oe_o <= 1'b1;
      if (pd_oe_o) rev_ack_no <= 1'b0;
    end else begin
      pd_oe_o <= 1'b0;
      if (!pd_oe_o) rev_ack_no <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= R_IDLE;
      byte_q <= '0;
      half_q <= 1'b0;
      pd_o   <= '0;
      stat_o <= '0;
      ack_no <= 1'b1;
    end else if (!(nib_i || granted)) begin
      st_q   <= R_IDLE;
      ack_no <= 1'b1;
    end else begin
      unique case (st_q)
        R_IDLE: if (tx_valid_i && tx_ready_o) begin
          byte_q <= tx_data_i;
          half_q <= 1'b0;
          if (nib_i) stat_o <= tx_data_i[NW-1:0];
          else       pd_o   <= tx_data_i;
          st_q <= R_SET;
        end
        R_SET: begin
          ack_no <= 1'b0;
          st_q   <= R_LOW;
        end
        R_LOW: if (autofd_s_i) begin
          ack_no <= 1'b1;
          st_q   <= R_REL;
        end
        R_REL: if (!autofd_s_i) begin
          if (nib_i && !half_q) begin
            stat_o <= byte_q[DW-1:DW-NW];
            half_q <= 1'b1;
            st_q   <= R_SET;
          end else begin
            st_q <= R_IDLE;
          end
        end
        default: st_q <= R_IDLE;
      endcase
    end
  end

  p_oe_after_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_oe_o |-> $past(!init_s_i));
  p_grant_after_oe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rev_ack_no) |-> pd_oe_o && $past(pd_oe_o));
  p_oe_off_before_ungrant_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rev_ack_no) |-> !pd_oe_o);
  p_data_setup_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_no) |-> $stable(stat_o) && $stable(pd_o));
endmodule

// File: rtl/pp_periph.sv
`timescale 1ns/1ps
module pp_periph #(
  parameter int DW    = 8,
  parameter int ACK_W = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic [DW-1:0] pd_i,
  output logic [DW-1:0] pd_o,
  output logic          pd_oe_o,
  input  logic          strobe_ni,
  input  logic          autofd_ni,
  input  logic          init_ni,
  output logic          busy_o,
  output logic          ack_no,
  output logic          rev_ack_no,
  output logic [3:0]    stat_o,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_cmd_o,
  output logic          rx_valid_o,
  input  logic          rx_ready_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          tx_valid_i,
  output logic          tx_ready_o
);
  import pp_pkg::*;

  pp_mode_e mode;
  logic [2:0] ctl_s;
  logic strobe_s, autofd_s, init_s;
  logic is_ecp, is_nib, fwd_en, rev_active;
  logic fwd_ack_n, rev_ack_n;

  assign mode = pp_mode_e'(mode_i);

  pp_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({init_ni, autofd_ni, strobe_ni}),
    .q_o (ctl_s)
  );
  assign {init_s, autofd_s, strobe_s} = ctl_s;

  assign is_ecp     = (mode == MODE_ECP);
  assign is_nib     = (mode == MODE_NIBBLE);
  assign rev_active = pd_oe_o | ~rev_ack_no;
  assign fwd_en     = (mode == MODE_COMPAT) | (is_ecp & ~rev_active);

  pp_fwd #(.DW(DW), .ACK_W(ACK_W)) u_fwd (
    .clk_i, .rst_ni,
    .en_i       (fwd_en),
    .ecp_i      (is_ecp),
    .pd_i,
    .strobe_s_i (strobe_s),
    .autofd_s_i (autofd_s),
    .rx_data_o, .rx_cmd_o, .rx_valid_o, .rx_ready_i,
    .busy_o,
    .ack_no     (fwd_ack_n)
  );

  pp_rev #(.DW(DW), .NW(4)) u_rev (
    .clk_i, .rst_ni,
    .nib_i      (is_nib),
    .ecp_i      (is_ecp),
    .autofd_s_i (autofd_s),
    .init_s_i   (init_s),
    .tx_data_i, .tx_valid_i, .tx_ready_o,
    .pd_o, .pd_oe_o, .rev_ack_no,
    .ack_no     (rev_ack_n),
    .stat_o
  );

  assign ack_no = fwd_ack_n & rev_ack_n;

  p_off_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode == MODE_OFF && $past(mode == MODE_OFF) && !$past(busy_o) |-> !busy_o && !rx_valid_o);
  p_capture_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_valid_o) |-> busy_o && $rose(busy_o));
endmodule

// File: tb/pp_periph_tb_top.sv
`timescale 1ns/1ps
module pp_periph_tb_top;
  localparam int ACK_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] pd_in = 8'h00;
  logic strobe_n = 1'b1, autofd_n = 1'b1, init_n = 1'b1;
  logic rx_ready = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic tx_valid = 1'b0;
  logic [7:0] pd_out, rx_data;
  logic [3:0] stat;
  logic pd_oe, busy, ack_n, rev_ack_n, rx_cmd, rx_valid, tx_ready;

  int checks = 0;
  int fails  = 0;
  int tx_beats = 0;
  int ack_lows = 0;

  always #2 clk = ~clk;

  pp_periph #(.DW(8), .ACK_W(ACK_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .pd_i(pd_in), .pd_o(pd_out), .pd_oe_o(pd_oe),
    .strobe_ni(strobe_n), .autofd_ni(autofd_n), .init_ni(init_n),
    .busy_o(busy), .ack_no(ack_n), .rev_ack_no(rev_ack_n), .stat_o(stat),
    .rx_data_o(rx_data), .rx_cmd_o(rx_cmd), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready)
  );

  always @(negedge clk) begin
    if (tx_ready && tx_valid) tx_beats++;
    if (!ack_n) ack_lows++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_ack(input logic lvl, input string req);
    int n = 0;
    while (ack_n !== lvl && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk({req, " ack level reached"}, 32'(ack_n), 32'(lvl));
  endtask

  task automatic wait_busy(input logic lvl, input string req);
    int n = 0;
    while (busy !== lvl && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk({req, " busy level reached"}, 32'(busy), 32'(lvl));
  endtask

  task automatic t_reset;
    chk("R1 busy", 32'(busy), 0);
    chk("R1 ack", 32'(ack_n), 1);
    chk("R1 oe", 32'(pd_oe), 0);
    chk("R1 rev_ack", 32'(rev_ack_n), 1);
    chk("R1 rx_valid", 32'(rx_valid), 0);
  endtask

  task automatic t_compat;
    int w;
    mode = 2'd0;
    pd_in = 8'hA5;
    @(negedge clk);
    strobe_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R2 busy before third edge", 32'(busy), 0);
    @(negedge clk);
    chk("R2 busy at third edge", 32'(busy), 1);
    chk("R2 rx_valid", 32'(rx_valid), 1);
    chk("R2 rx_data", 32'(rx_data), 32'hA5);
    chk("R2 rx_cmd", 32'(rx_cmd), 0);
    @(negedge clk);
    strobe_n = 1'b1;
    pd_in = 8'h00;
    repeat (20) @(negedge clk);
    chk("R3 busy held", 32'(busy), 1);
    chk("R3 valid held", 32'(rx_valid), 1);
    chk("R3 data held", 32'(rx_data), 32'hA5);
    chk("R3 no ack", 32'(ack_n), 1);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    chk("R3 valid dropped after accept", 32'(rx_valid), 0);
    wait_ack(1'b0, "R4");
    w = 0;
    while (ack_n === 1'b0 && w < 50) begin
      chk("R4 busy during ack", 32'(busy), 1);
      @(negedge clk);
      w++;
    end
    chk("R4 ack width", 32'(w), 32'(ACK_W));
    chk("R4 busy low with ack release", 32'(busy), 0);
  endtask

  task automatic t_ecp_fwd;
    int base;
    mode = 2'd2;
    autofd_n = 1'b1;
    repeat (4) @(negedge clk);
    base = ack_lows;
    pd_in = 8'h5A;
    strobe_n = 1'b0;
    wait_busy(1'b1, "R5 data");
    chk("R5 data byte", 32'(rx_data), 32'h5A);
    chk("R5 data flag", 32'(rx_cmd), 0);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    strobe_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R5 busy still high until strobe seen", 32'(busy), 1);
    wait_busy(1'b0, "R5 release");
    autofd_n = 1'b0;
    pd_in = 8'hC3;
    rx_ready = 1'b1;
    repeat (3) @(negedge clk);
    strobe_n = 1'b0;
    wait_busy(1'b1, "R5 cmd");
    chk("R5 cmd byte", 32'(rx_data), 32'hC3);
    chk("R5 cmd flag", 32'(rx_cmd), 1);
    chk("R5 cmd valid", 32'(rx_valid), 1);
    strobe_n = 1'b1;
    wait_busy(1'b0, "R5 cmd release");
    rx_ready = 1'b0;
    chk("R5 no ack pulse", 32'(ack_lows - base), 0);
    autofd_n = 1'b1;
  endtask

  task automatic t_nibble;
    int beats0;
    mode = 2'd1;
    repeat (3) @(negedge clk);
    beats0 = tx_beats;
    tx_data = 8'h3C;
    tx_valid = 1'b1;
    autofd_n = 1'b0;
    wait_ack(1'b0, "R6 first");
    tx_valid = 1'b0;
    chk("R6 low nibble first", 32'(stat), 32'hC);
    chk("R6 one ready beat", 32'(tx_beats - beats0), 1);
    autofd_n = 1'b1;
    wait_ack(1'b1, "R6 release1");
    autofd_n = 1'b0;
    wait_ack(1'b0, "R6 second");
    chk("R6 high nibble", 32'(stat), 32'h3);
    autofd_n = 1'b1;
    wait_ack(1'b1, "R6 release2");
    autofd_n = 1'b0;
    repeat (12) @(negedge clk);
    chk("R6 idle after byte", 32'(ack_n), 1);
    chk("R6 still one beat", 32'(tx_beats - beats0), 1);
    autofd_n = 1'b1;
  endtask

  task automatic t_ecp_rev;
    mode = 2'd2;
    autofd_n = 1'b0;
    repeat (4) @(negedge clk);
    init_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R7 oe before third edge", 32'(pd_oe), 0);
    @(negedge clk);
    chk("R7 oe at third edge", 32'(pd_oe), 1);
    chk("R7 grant trails oe", 32'(rev_ack_n), 1);
    @(negedge clk);
    chk("R7 grant", 32'(rev_ack_n), 0);
    tx_data = 8'h96;
    tx_valid = 1'b1;
    wait_ack(1'b0, "R8 strobe");
    tx_valid = 1'b0;
    chk("R8 byte on bus", 32'(pd_out), 32'h96);
    chk("R8 oe during byte", 32'(pd_oe), 1);
    autofd_n = 1'b1;
    wait_ack(1'b1, "R8 release");
    autofd_n = 1'b0;
    repeat (4) @(negedge clk);
    init_n = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk("R7 oe off first", 32'(pd_oe), 0);
    chk("R7 grant held", 32'(rev_ack_n), 0);
    @(negedge clk);
    chk("R7 grant removed", 32'(rev_ack_n), 1);
    autofd_n = 1'b1;
  endtask

  task automatic t_off;
    mode = 2'd3;
    pd_in = 8'h77;
    repeat (3) @(negedge clk);
    strobe_n = 1'b0;
    repeat (8) @(negedge clk);
    strobe_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R9 busy", 32'(busy), 0);
    chk("R9 rx_valid", 32'(rx_valid), 0);
    chk("R9 ack", 32'(ack_n), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_compat();
    t_ecp_fwd();
    t_nibble();
    t_ecp_rev();
    t_off();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule